// File: doc/BRIEF.md
# Two-Stage Cascaded Interrupt Controller

This block collects sixteen level-sensitive interrupt request lines and presents one interrupt line to a processor. It is built from two identical eight-line stages. The primary stage talks to the processor. The secondary stage's request output replaces primary line 2. Each stage has a mask, an in-service register and a vector base. The block picks the highest-priority request that is enabled and not blocked, raises `intr`, and answers an acknowledge strobe with an 8-bit vector. Each stage has its own end-of-interrupt command, so a routine that serves a cascaded line retires it in both stages.

The handshake is a small state machine with three states. `ST_IDLE` waits for an eligible request. `ST_ASSERT` drives `intr`. `ST_DELIVER` presents the vector for one cycle. The transitions are as follows:
- idle-to-assert when a request becomes eligible.
- assert-to-idle when the request vanishes before it is acknowledged.
- assert-to-deliver when an acknowledge arrives while a request is eligible.
- deliver-to-assert when a further eligible request exists.
- deliver-to-idle when none does.

Configuration uses a write strobe, a stage select and a 2-bit offset. The offsets are:
- offset 0: command.
- offset 1: mask.
- offset 2: vector base.

Top module: `pic_cascade`

## Requirements
- R1: After reset, `intr` and `vec_valid` are low, both masks are 0x00 (all lines enabled), no line is in service, and the vector bases are 0x08 (primary) and 0x70 (secondary).
- R2: Request lines are sampled once per clock. An enabled, unblocked request presented before clock edge k drives `intr` high after edge k+1, and not earlier.
- R3: Among simultaneous requests the winner follows the fixed order IRQ0, IRQ1, IRQ8 up to IRQ15, then IRQ3 up to IRQ7. Lower numbers win within a stage.
- R4: The vector for IRQ n, n < 8, is primary base + n. The vector for IRQ n, n >= 8, is secondary base + (n-8). A write at offset 2 with `cfg_stage` 0 (primary) or 1 (secondary) replaces that stage's base.
- R5: A write at offset 1 sets a stage's mask. A 1 in bit i disables that stage's line i. Primary mask bit 2 disables the whole secondary stage.
- R6: An acknowledge taken while `intr` is high lowers `intr` in the next cycle and raises `vec_valid` for exactly one cycle with the vector. An acknowledge while `intr` is low produces no `vec_valid`.
- R7: On acknowledge the winning line enters service. While a line is in service, requests of equal or lower priority do not raise `intr`, but a higher-priority request does.
- R8: Writing 0x20 at offset 0 clears only the highest-priority in-service bit of that stage. Any other value written at offset 0 has no effect.
- R9: A request still held after its end-of-interrupt raises `intr` again and is served again.
- R10: Acknowledging a secondary line puts primary line 2 and the secondary line in service. A secondary end-of-interrupt alone does not let further secondary requests through. The primary end-of-interrupt then does.
- R11: Input `irq_in[2]` has no effect, because that primary line is taken by the cascade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Level request lines IRQ0..IRQ15 (bit 2 unused) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stage | input | 1 | Stage select: 0 primary, 1 secondary |
| cfg_ofs | input | 2 | Offset: 0 command, 1 mask, 2 vector base |
| cfg_wdata | input | 8 | Write data |
| inta | input | 1 | Acknowledge strobe from the processor |
| intr | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector present this cycle |
| vec_out | output | 8 | Interrupt vector |

## Verification
The hardest state to reach from the ports is a cascaded line that is half retired. In that state the secondary stage has taken its end-of-interrupt and still has a pending line, while primary line 2 is still in service. The bench reaches it by raising IRQ10 and IRQ11 together and acknowledging IRQ10. It then drops IRQ10, retires only the secondary stage, and confirms that `intr` stays low. Only after the primary end-of-interrupt does it expect IRQ11's vector.

Nested service is reached in a similar way. A held IRQ5 is acknowledged, and then IRQ1 pre-empts it. This shows three things: an end-of-interrupt pops just one level, a bogus command byte changes nothing, and the still-held line is served again.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int VEC_W = 8;

    localparam logic [1:0] OFS_CMD  = 2'd0;
    localparam logic [1:0] OFS_MASK = 2'd1;
    localparam logic [1:0] OFS_BASE = 2'd2;

    localparam logic [VEC_W-1:0] EOI_CMD = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ASSERT  = 2'd1,
        ST_DELIVER = 2'd2
    } ack_state_t;
endpackage

// File: rtl/pic_stage.sv
module pic_stage
    import pic_pkg::*;
#(
    parameter int               LINES    = 8,
    parameter int               VW       = VEC_W,
    parameter logic [VW-1:0]    BASE_RST = 8'h08,
    localparam int              IW       = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             wr_en,
    input  logic [1:0]       wr_ofs,
    input  logic [VW-1:0]    wr_data,
    input  logic [LINES-1:0] ack_set,
    output logic             req,
    output logic [IW-1:0]    win_idx,
    output logic [VW-1:0]    base
);
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] isr_q;
    logic [LINES-1:0] allowed;
    logic [LINES-1:0] eligible;
    logic [LINES-1:0] eoi_clr;
    logic [VW-1:0]    base_q;
    logic             eoi_hit;

    // A line may request only if no line of equal or higher priority is in service.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            allowed[i] = (isr_q & ((LINES'(2) << i) - LINES'(1))) == '0;
        end
    end

    assign eligible = lines & ~mask_q & allowed;
    assign req      = |eligible;

    always_comb begin
        win_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (eligible[i]) win_idx = IW'(i);
        end
    end

    assign eoi_hit = wr_en && (wr_ofs == OFS_CMD) && (wr_data == EOI_CMD);
    assign eoi_clr = isr_q & (~isr_q + LINES'(1));
    assign base    = base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            isr_q  <= '0;
            base_q <= BASE_RST;
        end else begin
            if (wr_en && wr_ofs == OFS_MASK) mask_q <= wr_data[LINES-1:0];
            if (wr_en && wr_ofs == OFS_BASE) base_q <= wr_data;
            isr_q <= (isr_q & ~(eoi_hit ? eoi_clr : '0)) | ack_set;
        end
    end

    // R8: a lone end-of-interrupt retires exactly one in-service level
    p_eoi_one_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && (isr_q != '0) && (ack_set == '0))
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

    // R7: acknowledge only promotes a line that is currently eligible
    p_ack_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_set != '0) |-> ((ack_set & eligible) != '0));

    // R6: one line enters service per acknowledge
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_set));

    // R7: nothing outranks line 0 while it is in service
    p_top_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q[0] |-> !req);
endmodule

// File: rtl/pic_ack_fsm.sv
module pic_ack_fsm
    import pic_pkg::*;
#(
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_in,
    input  logic          ack_in,
    input  logic [VW-1:0] vec_in,
    output logic          intr,
    output logic          take,
    output logic          vec_valid,
    output logic [VW-1:0] vec_out
);
    ack_state_t    state_q, state_d;
    logic [VW-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) vec_q <= vec_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = req_in ? ST_ASSERT : ST_IDLE;
            ST_ASSERT:  state_d = take ? ST_DELIVER : (req_in ? ST_ASSERT : ST_IDLE);
            ST_DELIVER: state_d = req_in ? ST_ASSERT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        intr      = (state_q == ST_ASSERT);
        vec_valid = (state_q == ST_DELIVER);
        take      = (state_q == ST_ASSERT) && ack_in && req_in;
        vec_out   = vec_q;
    end

    // R6: intr falls right after an accepted acknowledge
    p_intr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && ack_in && req_in) |=> !intr);

    // R6: vector strobe lasts one cycle
    p_vec_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R2: intr only rises after an eligible request was seen
    p_rise_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intr) |-> $past(req_in));
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
    import pic_pkg::*;
#(
    parameter int            LINES        = 8,
    parameter int            VW           = VEC_W,
    parameter int            CASCADE_LINE = 2,
    parameter logic [VW-1:0] M_BASE_RST   = 8'h08,
    parameter logic [VW-1:0] S_BASE_RST   = 8'h70,
    localparam int           IW           = $clog2(LINES),
    localparam int           TOTAL        = 2 * LINES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TOTAL-1:0] irq_in,
    input  logic             cfg_we,
    input  logic             cfg_stage,
    input  logic [1:0]       cfg_ofs,
    input  logic [VW-1:0]    cfg_wdata,
    input  logic             inta,
    output logic             intr,
    output logic             vec_valid,
    output logic [VW-1:0]    vec_out
);
    logic [TOTAL-1:0] irq_q;
    logic [LINES-1:0] m_lines, m_ack_set, s_ack_set;
    logic             m_req, s_req, take;
    logic [IW-1:0]    m_idx, s_idx;
    logic [VW-1:0]    m_base, s_base, vec_sel;
    logic             from_slave;
    logic             unused_cascade_pin;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_in;
    end

    assign unused_cascade_pin = irq_q[CASCADE_LINE];

    for (genvar g = 0; g < LINES; g++) begin : g_mline
        if (g == CASCADE_LINE) begin : g_casc
            assign m_lines[g] = s_req;
        end else begin : g_pin
            assign m_lines[g] = irq_q[g];
        end
    end

    pic_stage #(.LINES(LINES), .VW(VW), .BASE_RST(S_BASE_RST)) u_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (irq_q[TOTAL-1:LINES]),
        .wr_en   (cfg_we && cfg_stage),
        .wr_ofs  (cfg_ofs),
        .wr_data (cfg_wdata),
        .ack_set (s_ack_set),
        .req     (s_req),
        .win_idx (s_idx),
        .base    (s_base)
    );

    pic_stage #(.LINES(LINES), .VW(VW), .BASE_RST(M_BASE_RST)) u_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines   (m_lines),
        .wr_en   (cfg_we && !cfg_stage),
        .wr_ofs  (cfg_ofs),
        .wr_data (cfg_wdata),
        .ack_set (m_ack_set),
        .req     (m_req),
        .win_idx (m_idx),
        .base    (m_base)
    );

    assign from_slave = (m_idx == IW'(CASCADE_LINE));
    assign m_ack_set  = take ? (LINES'(1) << m_idx) : '0;
    assign s_ack_set  = (take && from_slave) ? (LINES'(1) << s_idx) : '0;
    assign vec_sel    = from_slave ? (s_base + VW'(s_idx)) : (m_base + VW'(m_idx));

    pic_ack_fsm #(.VW(VW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (m_req),
        .ack_in    (inta),
        .vec_in    (vec_sel),
        .intr      (intr),
        .take      (take),
        .vec_valid (vec_valid),
        .vec_out   (vec_out)
    );

    // R10: a cascaded acknowledge fills both stages
    p_cascade_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && from_slave) |-> s_req);
endmodule

// File: tb/pic_cascade_test.sv
module pic_cascade_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_stage = 1'b0;
    logic [1:0]  cfg_ofs = 2'd0;
    logic [7:0]  cfg_wdata = '0;
    logic        inta = 1'b0;
    logic        intr, vec_valid;
    logic [7:0]  vec_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pic_cascade uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_stage(cfg_stage), .cfg_ofs(cfg_ofs), .cfg_wdata(cfg_wdata),
        .inta(inta), .intr(intr), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    // {irq pattern, intr expected, vector expected}
    localparam logic [24:0] VEC_TBL [0:8] = '{
        {16'hFFFF, 1'b1, 8'h08},
        {16'hFFFE, 1'b1, 8'h09},
        {16'hFFFC, 1'b1, 8'h70},
        {16'hFEF8, 1'b1, 8'h71},
        {16'h80F8, 1'b1, 8'h77},
        {16'h00F8, 1'b1, 8'h0B},
        {16'h0080, 1'b1, 8'h0F},
        {16'h4010, 1'b1, 8'h76},
        {16'h0004, 1'b0, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic stg, input logic [1:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stage = stg; cfg_ofs = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ack(output logic v, output logic [7:0] vec, output logic i);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vec_valid; vec = vec_out; i = intr;
    endtask

    task automatic raise(input logic [15:0] pat);
        @(negedge clk);
        irq_in = pat;
    endtask

    task automatic cleanup();
        @(negedge clk);
        irq_in = '0;
        wr(1'b1, 2'd0, 8'h20);
        wr(1'b0, 2'd0, 8'h20);
        repeat (2) @(negedge clk);
    endtask

    task automatic ack_expect(input string tag, input logic [7:0] exp);
        logic v, i;
        logic [7:0] vec;
        ack(v, vec, i);
        chk({tag, " vec_valid"}, 32'(v), 32'd1);
        chk({tag, " vector"}, 32'(vec), 32'(exp));
        chk("R6 intr low after ack", 32'(i), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic v, i;
        logic [7:0] vec;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 intr after reset", 32'(intr), 32'd0);
        chk("R1 vec_valid after reset", 32'(vec_valid), 32'd0);

        // R2 latency
        raise(16'h0001);
        @(negedge clk);
        chk("R2 intr not yet", 32'(intr), 32'd0);
        @(negedge clk);
        chk("R2 intr raised", 32'(intr), 32'd1);
        ack_expect("R2", 8'h08);
        cleanup();

        // table: R3 priority, R4 default bases (R1), R11 line 2 ignored
        for (int k = 0; k < 9; k++) begin
            raise(VEC_TBL[k][24:9]);
            if (VEC_TBL[k][8]) begin
                repeat (2) @(negedge clk);
                chk("R3 intr for pattern", 32'(intr), 32'd1);
                ack_expect("R3 R4", VEC_TBL[k][7:0]);
            end else begin
                repeat (3) @(negedge clk);
                chk("R11 irq_in[2] ignored", 32'(intr), 32'd0);
            end
            cleanup();
            chk("R8 idle after cleanup", 32'(intr), 32'd0);
        end

        // R6 acknowledge while idle
        ack(v, vec, i);
        chk("R6 no vector without intr", 32'(v), 32'd0);

        // R5 masking
        wr(1'b0, 2'd1, 8'h7E);
        raise(16'h0008);
        repeat (3) @(negedge clk);
        chk("R5 masked IRQ3", 32'(intr), 32'd0);
        raise(16'h0088);
        repeat (2) @(negedge clk);
        chk("R5 IRQ7 enabled", 32'(intr), 32'd1);
        ack_expect("R5", 8'h0F);
        cleanup();
        wr(1'b0, 2'd1, 8'h04);
        raise(16'h0400);
        repeat (3) @(negedge clk);
        chk("R5 primary bit 2 masks secondary", 32'(intr), 32'd0);
        cleanup();
        wr(1'b0, 2'd1, 8'h00);
        wr(1'b1, 2'd1, 8'h01);
        raise(16'h0300);
        repeat (2) @(negedge clk);
        ack_expect("R5 secondary mask", 8'h71);
        cleanup();
        wr(1'b1, 2'd1, 8'h00);

        // R4 base writes
        wr(1'b0, 2'd2, 8'h20);
        wr(1'b1, 2'd2, 8'h50);
        raise(16'h0020);
        repeat (2) @(negedge clk);
        ack_expect("R4 primary base", 8'h25);
        cleanup();
        raise(16'h1000);
        repeat (2) @(negedge clk);
        ack_expect("R4 secondary base", 8'h54);
        cleanup();
        wr(1'b0, 2'd2, 8'h08);
        wr(1'b1, 2'd2, 8'h70);

        // R7 nesting, R8 EOI, R9 re-service
        raise(16'h0020);
        repeat (2) @(negedge clk);
        ack_expect("R7 IRQ5", 8'h0D);
        raise(16'h0060);
        repeat (3) @(negedge clk);
        chk("R7 lower blocked", 32'(intr), 32'd0);
        raise(16'h0062);
        repeat (2) @(negedge clk);
        chk("R7 higher preempts", 32'(intr), 32'd1);
        ack_expect("R7 IRQ1", 8'h09);
        raise(16'h0060);
        repeat (2) @(negedge clk);
        wr(1'b0, 2'd0, 8'h20);
        repeat (3) @(negedge clk);
        chk("R8 one level popped", 32'(intr), 32'd0);
        wr(1'b0, 2'd0, 8'h11);
        repeat (2) @(negedge clk);
        chk("R8 other command ignored", 32'(intr), 32'd0);
        wr(1'b0, 2'd0, 8'h20);
        @(negedge clk);
        chk("R9 held line reasserts", 32'(intr), 32'd1);
        ack_expect("R9", 8'h0D);
        cleanup();

        // R10 cascade retirement
        raise(16'h0C00);
        repeat (2) @(negedge clk);
        ack_expect("R10 IRQ10", 8'h72);
        raise(16'h0800);
        repeat (2) @(negedge clk);
        wr(1'b1, 2'd0, 8'h20);
        repeat (3) @(negedge clk);
        chk("R10 secondary EOI alone", 32'(intr), 32'd0);
        wr(1'b0, 2'd0, 8'h20);
        @(negedge clk);
        chk("R10 after primary EOI", 32'(intr), 32'd1);
        ack_expect("R10 IRQ11", 8'h73);
        cleanup();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule